// File: doc/BRIEF.md
# Indirect Pointer Address Generator

This block turns a pointer-register request into an effective memory address for indirect loads and stores. One of the three 16-bit pointer pairs in the register file (X in R27:R26, Y in R29:R28, Z in R31:R30) is read by the caller and presented together with an addressing mode, an unsigned displacement, an extension byte and the target space. The block returns the address to access, the new pointer value together with the register indices to write it to, and, for the extended program space, the new extension byte.

Data-space accesses support four modes: plain, post-increment, pre-decrement and displacement. Program-space byte loads always use Z and allow only plain and post-increment. The extended program space prepends the extension byte to Z, making a 24-bit address. Its post-increment carries from Z into the extension byte. Any illegal combination is flagged and all write-backs are suppressed. For extended reads past the end of program memory, the block raises a flag telling the memory to return 0xFF.

All results are registered and appear exactly one clock after the request.

Top module: `ptr_addr_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid`, `out_err`, `ptr_wb_en`, `ext_wb_en` and `out_fill_ff` are 0.
- R2: Every result appears on the clock edge after the request. `out_valid` is 1 exactly when `in_valid` was 1 at the previous edge, and all enables and flags are 0 when `out_valid` is 0.
- R3: `in_pair` selects the pair: 0 is X (low index 26), 1 is Y (28) and 2 is Z (30). `ptr_wb_hi_idx` is always the low index plus 1. In plain data mode (`in_mode`=0) the address is the pointer and `ptr_wb_en` is 0.
- R4: In pre-decrement mode (`in_mode`=2), the address is pointer minus 1, wrapping at 16 bits. The same value is written back with `ptr_wb_en`=1.
- R5: In post-increment mode (`in_mode`=1), the address is the unchanged pointer. Pointer plus 1, wrapping at 16 bits, is written back with `ptr_wb_en`=1.
- R6: In displacement mode (`in_mode`=3), the address is the pointer plus the zero-extended `in_disp`, wrapping at 16 bits, and `ptr_wb_en` is 0.
- R7: Program-space loads (`in_space`=1) ignore `in_pair` and use Z (indices 30/31). The address is {8'h00, Z}. Post-increment writes back Z+1, wrapping at 16 bits, and `ext_wb_en` stays 0.
- R8: Extended program loads (`in_space`=2) use the address {`in_ext`, Z}. Post-increment adds 1 to the 24-bit value, wrapping at 24 bits. Bits 15:0 go to `ptr_wb_val` and bits 23:16 go to `ext_wb_val` with `ext_wb_en`=1.
- R9: `out_fill_ff` is 1 only for a legal extended program load whose address is at least `PROG_BYTES` (default 131072).
- R10: A program-space request in pre-decrement or displacement mode, `in_space`=3, or a data request with `in_pair`=3, sets `out_err`=1. In that case `out_addr`, `ptr_wb_en`, `ext_wb_en` and `out_fill_ff` are 0.
- R11: For data and non-extended program accesses, `out_addr[23:16]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_space | input | 2 | 0 data, 1 program, 2 extended program, 3 reserved |
| in_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| in_pair | input | 2 | 0 X, 1 Y, 2 Z, 3 reserved |
| in_ptr | input | 16 | Current value of the selected pointer pair |
| in_disp | input | 6 | Unsigned displacement |
| in_ext | input | 8 | Extension byte for the extended program space |
| out_valid | output | 1 | Result present |
| out_err | output | 1 | Illegal request |
| out_addr | output | 24 | Effective address |
| out_fill_ff | output | 1 | Extended read beyond memory; return 0xFF |
| ptr_wb_en | output | 1 | Write pointer pair back |
| ptr_wb_val | output | 16 | New pointer value |
| ptr_wb_lo_idx | output | 5 | Register index for the low byte |
| ptr_wb_hi_idx | output | 5 | Register index for the high byte |
| ext_wb_en | output | 1 | Write extension byte back |
| ext_wb_val | output | 8 | New extension byte |

## Verification
Every output is registered, so the result of a request sampled at one rising edge is due just after that edge and stays there until the next one. The bench drives each request on a falling edge and pushes the expected result into a queue. On the next falling edge, one full clock later, it pops that entry and compares it with the outputs. An idle cycle therefore has to show `out_valid` low in the very next cycle, and a back-to-back stream checks each result in its own cycle with no slack.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;

    localparam int IDX_W = 5;

    typedef enum logic [1:0] {
        SPACE_DATA     = 2'd0,
        SPACE_PROG     = 2'd1,
        SPACE_PROG_EXT = 2'd2,
        SPACE_RSVD     = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        MODE_PLAIN   = 2'd0,
        MODE_POSTINC = 2'd1,
        MODE_PREDEC  = 2'd2,
        MODE_DISP    = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        PAIR_X    = 2'd0,
        PAIR_Y    = 2'd1,
        PAIR_Z    = 2'd2,
        PAIR_RSVD = 2'd3
    } pair_e;

    typedef struct packed {
        logic  legal;
        logic  wb_ptr;
        logic  wb_ext;
        logic  pre_dec;
        logic  disp_add;
        logic  ext_addr;
        pair_e pair_eff;
    } addr_ctrl_t;

    // Low-byte register index of a pair; pairs sit two indices apart.
    function automatic logic [IDX_W-1:0] pair_low_idx(pair_e p, logic [IDX_W-1:0] base);
        return base + {{(IDX_W-3){1'b0}}, p, 1'b0};
    endfunction

endpackage

// File: rtl/ptr_mode_decode.sv
module ptr_mode_decode
    import ptr_addr_pkg::*;
(
    input  space_e     space,
    input  mode_e      mode,
    input  pair_e      pair,
    output addr_ctrl_t ctrl
);
    always_comb begin
        ctrl          = '0;
        ctrl.pair_eff = PAIR_Z;
        case (space)
            SPACE_DATA: begin
                ctrl.legal    = (pair != PAIR_RSVD);
                ctrl.pair_eff = pair;
                ctrl.pre_dec  = (mode == MODE_PREDEC);
                ctrl.disp_add = (mode == MODE_DISP);
                ctrl.wb_ptr   = ctrl.legal &&
                                (mode == MODE_PREDEC || mode == MODE_POSTINC);
            end
            SPACE_PROG, SPACE_PROG_EXT: begin
                ctrl.legal    = (mode == MODE_PLAIN || mode == MODE_POSTINC);
                ctrl.ext_addr = (space == SPACE_PROG_EXT);
                ctrl.wb_ptr   = (mode == MODE_POSTINC);
                ctrl.wb_ext   = (mode == MODE_POSTINC) && (space == SPACE_PROG_EXT);
            end
            default: ctrl.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptr_arith.sv
module ptr_arith #(
    parameter int PTR_W  = 16,
    parameter int EXT_W  = 8,
    parameter int DISP_W = 6,
    localparam int ADDR_W = PTR_W + EXT_W
) (
    input  logic [PTR_W-1:0]  ptr,
    input  logic [DISP_W-1:0] disp,
    input  logic [EXT_W-1:0]  ext,
    input  logic              pre_dec,
    input  logic              disp_add,
    input  logic              ext_addr,
    output logic [ADDR_W-1:0] addr,
    output logic [PTR_W-1:0]  next_ptr,
    output logic [EXT_W-1:0]  next_ext
);
    localparam logic [PTR_W-1:0]  PTR_ONE  = PTR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [PTR_W-1:0]  ptr_dec;
    logic [PTR_W-1:0]  disp_sum;
    logic [ADDR_W-1:0] full;
    logic [ADDR_W-1:0] full_inc;

    always_comb begin
        ptr_dec  = ptr - PTR_ONE;
        disp_sum = ptr + {{(PTR_W-DISP_W){1'b0}}, disp};
        full     = {ext, ptr};
        // One wide incrementer serves both the 16-bit and the 24-bit post-increment.
        full_inc = full + ADDR_ONE;

        if (ext_addr)
            addr = full;
        else if (pre_dec)
            addr = {{EXT_W{1'b0}}, ptr_dec};
        else if (disp_add)
            addr = {{EXT_W{1'b0}}, disp_sum};
        else
            addr = {{EXT_W{1'b0}}, ptr};

        next_ptr = pre_dec ? ptr_dec : full_inc[PTR_W-1:0];
        next_ext = full_inc[ADDR_W-1:PTR_W];
    end
endmodule

// File: rtl/ptr_range_check.sv
module ptr_range_check #(
    parameter int ADDR_W     = 24,
    parameter int PROG_BYTES = 131072
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_addr,
    output logic              fill_ff
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(PROG_BYTES);

    always_comb fill_ff = ext_addr && ({1'b0, addr} >= LIMIT);
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
    import ptr_addr_pkg::*;
#(
    parameter int PTR_W      = 16,
    parameter int EXT_W      = 8,
    parameter int DISP_W     = 6,
    parameter int PROG_BYTES = 131072,
    parameter logic [IDX_W-1:0] X_LOW_IDX = 5'd26
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [1:0]              in_space,
    input  logic [1:0]              in_mode,
    input  logic [1:0]              in_pair,
    input  logic [PTR_W-1:0]        in_ptr,
    input  logic [DISP_W-1:0]       in_disp,
    input  logic [EXT_W-1:0]        in_ext,
    output logic                    out_valid,
    output logic                    out_err,
    output logic [PTR_W+EXT_W-1:0]  out_addr,
    output logic                    out_fill_ff,
    output logic                    ptr_wb_en,
    output logic [PTR_W-1:0]        ptr_wb_val,
    output logic [IDX_W-1:0]        ptr_wb_lo_idx,
    output logic [IDX_W-1:0]        ptr_wb_hi_idx,
    output logic                    ext_wb_en,
    output logic [EXT_W-1:0]        ext_wb_val
);
    localparam int ADDR_W = PTR_W + EXT_W;
    localparam logic [ADDR_W:0]   FILL_LIMIT = (ADDR_W+1)'(PROG_BYTES);
    localparam logic [IDX_W-1:0]  IDX_ONE    = IDX_W'(1);
    localparam logic [PTR_W-1:0]  PTR_ONE    = PTR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE   = ADDR_W'(1);

    addr_ctrl_t        ctrl;
    logic [ADDR_W-1:0] addr_c;
    logic [PTR_W-1:0]  next_ptr_c;
    logic [EXT_W-1:0]  next_ext_c;
    logic              fill_c;
    logic [IDX_W-1:0]  lo_idx_c;

    ptr_mode_decode u_decode (
        .space (space_e'(in_space)),
        .mode  (mode_e'(in_mode)),
        .pair  (pair_e'(in_pair)),
        .ctrl  (ctrl)
    );

    ptr_arith #(.PTR_W(PTR_W), .EXT_W(EXT_W), .DISP_W(DISP_W)) u_arith (
        .ptr      (in_ptr),
        .disp     (in_disp),
        .ext      (in_ext),
        .pre_dec  (ctrl.pre_dec),
        .disp_add (ctrl.disp_add),
        .ext_addr (ctrl.ext_addr),
        .addr     (addr_c),
        .next_ptr (next_ptr_c),
        .next_ext (next_ext_c)
    );

    ptr_range_check #(.ADDR_W(ADDR_W), .PROG_BYTES(PROG_BYTES)) u_range (
        .addr     (addr_c),
        .ext_addr (ctrl.ext_addr),
        .fill_ff  (fill_c)
    );

    always_comb lo_idx_c = pair_low_idx(ctrl.pair_eff, X_LOW_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            out_err       <= 1'b0;
            out_addr      <= '0;
            out_fill_ff   <= 1'b0;
            ptr_wb_en     <= 1'b0;
            ptr_wb_val    <= '0;
            ptr_wb_lo_idx <= '0;
            ptr_wb_hi_idx <= '0;
            ext_wb_en     <= 1'b0;
            ext_wb_val    <= '0;
        end else begin
            out_valid <= in_valid;
            out_err   <= in_valid && !ctrl.legal;
            if (in_valid && ctrl.legal) begin
                out_addr      <= addr_c;
                out_fill_ff   <= fill_c;
                ptr_wb_en     <= ctrl.wb_ptr;
                ptr_wb_val    <= next_ptr_c;
                ptr_wb_lo_idx <= lo_idx_c;
                ptr_wb_hi_idx <= lo_idx_c + IDX_ONE;
                ext_wb_en     <= ctrl.wb_ext;
                ext_wb_val    <= next_ext_c;
            end else begin
                out_addr      <= '0;
                out_fill_ff   <= 1'b0;
                ptr_wb_en     <= 1'b0;
                ptr_wb_val    <= '0;
                ptr_wb_lo_idx <= '0;
                ptr_wb_hi_idx <= '0;
                ext_wb_en     <= 1'b0;
                ext_wb_val    <= '0;
            end
        end
    end

    // R2: a request produces a result one edge later, an idle cycle produces none
    assert_result_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !ptr_wb_en && !ext_wb_en && !out_err);

    // R3: the high byte index sits right above the low byte index
    assert_pair_step_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ptr_wb_en) |-> ptr_wb_hi_idx == ptr_wb_lo_idx + IDX_ONE);

    // R4: pre-decrement writes back the address that was accessed
    assert_predec_same_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ptr_wb_en && $past(in_mode) == 2'd2)
        |-> ptr_wb_val == out_addr[PTR_W-1:0]);

    // R5: 16-bit post-increment writes back the accessed pointer plus one
    assert_postinc_next_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ptr_wb_en && !ext_wb_en && $past(in_mode) == 2'd1)
        |-> ptr_wb_val == out_addr[PTR_W-1:0] + PTR_ONE);

    // R6: displacement mode never updates the pointer
    assert_disp_no_wb_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_mode) == 2'd3) |-> !ptr_wb_en);

    // R8: the extension byte and pointer together hold the 24-bit address plus one
    assert_ext_carry_R8: assert property (@(posedge clk) disable iff (rst)
        ext_wb_en |-> ptr_wb_en && {ext_wb_val, ptr_wb_val} == out_addr + ADDR_ONE);

    // R9: the fill flag only ever marks an address beyond program memory
    assert_fill_range_R9: assert property (@(posedge clk) disable iff (rst)
        out_fill_ff |-> out_valid && ({1'b0, out_addr} >= FILL_LIMIT));

    // R10: an error suppresses every write-back
    assert_err_blocks_wb_R10: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_valid && !ptr_wb_en && !ext_wb_en && !out_fill_ff);
endmodule

// File: tb/tb_ptr_addr_gen.sv
module tb_ptr_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int PROG_BYTES = 131072;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_space = '0;
    logic [1:0]  in_mode = '0;
    logic [1:0]  in_pair = '0;
    logic [15:0] in_ptr = '0;
    logic [5:0]  in_disp = '0;
    logic [7:0]  in_ext = '0;
    logic        out_valid, out_err, out_fill_ff, ptr_wb_en, ext_wb_en;
    logic [23:0] out_addr;
    logic [15:0] ptr_wb_val;
    logic [4:0]  ptr_wb_lo_idx, ptr_wb_hi_idx;
    logic [7:0]  ext_wb_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_addr_gen dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_space(in_space),
        .in_mode(in_mode), .in_pair(in_pair), .in_ptr(in_ptr), .in_disp(in_disp),
        .in_ext(in_ext), .out_valid(out_valid), .out_err(out_err),
        .out_addr(out_addr), .out_fill_ff(out_fill_ff), .ptr_wb_en(ptr_wb_en),
        .ptr_wb_val(ptr_wb_val), .ptr_wb_lo_idx(ptr_wb_lo_idx),
        .ptr_wb_hi_idx(ptr_wb_hi_idx), .ext_wb_en(ext_wb_en), .ext_wb_val(ext_wb_val)
    );

    typedef struct {
        bit valid; bit err; int addr; bit fill;
        bit pwb; int pval; int lo; int hi; bit ewb; int eval;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;

    function automatic exp_t model(bit v, int sp, int md, int pr, int p, int d, int e);
        exp_t r = '{default: 0};
        bit   legal;
        int   pe;
        int   full;
        int   n;
        r.valid = v;
        if (!v) return r;
        legal = (sp != 3) && !(sp == 0 && pr == 3) && !(sp != 0 && md > 1);
        r.err = !legal;
        if (!legal) return r;
        pe = (sp == 0) ? pr : 2;
        r.lo = 26 + 2 * pe;
        r.hi = r.lo + 1;
        if (sp == 0) begin
            case (md)
                0: r.addr = p;
                1: begin r.addr = p; r.pwb = 1; r.pval = (p + 1) % 65536; end
                2: begin r.addr = (p + 65535) % 65536; r.pwb = 1; r.pval = r.addr; end
                default: r.addr = (p + d) % 65536;
            endcase
            r.pval = r.pwb ? r.pval : (md == 2 ? r.addr : (p + 1) % 65536);
            r.eval = (md == 2) ? 0 : ((p + 1) >= 65536 ? 1 : 0);
        end else if (sp == 1) begin
            r.addr = p;
            r.pwb  = (md == 1);
            r.pval = (p + 1) % 65536;
        end else begin
            full   = e * 65536 + p;
            r.addr = full;
            r.fill = (full >= PROG_BYTES);
            n      = (full + 1) % 16777216;
            r.pwb  = (md == 1);
            r.ewb  = (md == 1);
            r.pval = n % 65536;
            r.eval = n / 65536;
        end
        return r;
    endfunction

    function automatic string pick_tag(int sp, int md, int pr);
        if (sp == 3 || (sp == 0 && pr == 3) || (sp != 0 && md > 1)) return "R10";
        if (sp == 2) return (md == 1) ? "R8" : "R9";
        if (sp == 1) return "R7";
        case (md)
            1: return "R5";
            2: return "R4";
            3: return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic check_one(string tag, string what, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Compares the outputs with the entry pushed one clock earlier.
    task automatic compare_front();
        exp_t  x;
        string t;
        int    bad;
        if (exp_q.size() == 0) return;
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        bad = 0;
        n_checks++;
        if (out_valid != x.valid) bad = 1;
        if (x.valid) begin
            if (out_err != x.err || out_addr != 24'(x.addr) || out_fill_ff != x.fill ||
                ptr_wb_en != x.pwb || ext_wb_en != x.ewb) bad = 1;
            if (x.pwb && (ptr_wb_val != 16'(x.pval) || ptr_wb_lo_idx != 5'(x.lo) ||
                          ptr_wb_hi_idx != 5'(x.hi))) bad = 1;
            if (x.ewb && ext_wb_val != 8'(x.eval)) bad = 1;
            // R11: upper address byte is zero outside the extended space
            if (!x.err && x.addr < 65536 && out_addr[23:16] != 8'h00) bad = 1;
        end else if (ptr_wb_en || ext_wb_en || out_err || out_fill_ff) begin
            bad = 1;
        end
        if (bad) begin
            n_fail++;
            $display("FAIL %s: actual v=%0b err=%0b addr=%06h fill=%0b pwb=%0b pval=%04h lo=%0d hi=%0d ewb=%0b eval=%02h expected v=%0b err=%0b addr=%06h fill=%0b pwb=%0b pval=%04h lo=%0d hi=%0d ewb=%0b eval=%02h",
                     t, out_valid, out_err, out_addr, out_fill_ff, ptr_wb_en, ptr_wb_val,
                     ptr_wb_lo_idx, ptr_wb_hi_idx, ext_wb_en, ext_wb_val,
                     x.valid, x.err, x.addr, x.fill, x.pwb, x.pval, x.lo, x.hi, x.ewb, x.eval);
        end
    endtask

    task automatic step(bit v, int sp, int md, int pr, int p, int d, int e, string tag);
        @(negedge clk);
        compare_front();
        in_valid = v;
        in_space = 2'(sp);
        in_mode  = 2'(md);
        in_pair  = 2'(pr);
        in_ptr   = 16'(p);
        in_disp  = 6'(d);
        in_ext   = 8'(e);
        exp_q.push_back(model(v, sp, md, pr, p, d, e));
        tag_q.push_back(tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        // R1: outputs quiet under reset, request inputs ignored
        in_valid = 1'b1;
        in_mode  = 2'd1;
        repeat (3) @(negedge clk);
        check_one("R1", "out_valid", int'(out_valid), 0);
        check_one("R1", "enables", int'({ptr_wb_en, ext_wb_en, out_err, out_fill_ff}), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        exp_q.push_back(model(0, 0, 0, 0, 0, 0, 0));
        tag_q.push_back("R1");

        // R3: pair mapping and plain data mode
        step(1, 0, 0, 0, 16'h1234, 0, 0, "R3");
        step(1, 0, 1, 0, 16'h0100, 0, 0, "R3");
        step(1, 0, 1, 1, 16'h0200, 0, 0, "R3");
        step(1, 0, 1, 2, 16'h0300, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, 0, "R2");
        // R4: pre-decrement, including wrap below zero
        step(1, 0, 2, 1, 16'h0000, 0, 0, "R4");
        step(1, 0, 2, 2, 16'h8000, 0, 0, "R4");
        // R5: post-increment, including wrap at the top
        step(1, 0, 1, 0, 16'hFFFF, 0, 0, "R5");
        step(1, 0, 1, 1, 16'h7FFF, 0, 0, "R5");
        // R6: displacement with wrap, no write-back
        step(1, 0, 3, 1, 16'hFFF0, 63, 0, "R6");
        step(1, 0, 3, 2, 16'h1000, 5, 0, "R6");
        // R7: program space forces Z, no extension write-back
        step(1, 1, 0, 0, 16'h0100, 0, 8'h05, "R7");
        step(1, 1, 1, 1, 16'hFFFF, 0, 8'h05, "R7");
        // R8: extended post-increment carries into the extension byte
        step(1, 2, 1, 0, 16'hFFFF, 0, 8'h01, "R8");
        step(1, 2, 1, 0, 16'hFFFF, 0, 8'hFF, "R8");
        step(1, 2, 1, 0, 16'h1234, 0, 8'h00, "R8");
        // R9: fill flag at and around the memory size
        step(1, 2, 0, 0, 16'h0000, 0, 8'h02, "R9");
        step(1, 2, 0, 0, 16'hFFFF, 0, 8'h01, "R9");
        step(1, 1, 0, 0, 16'hFFFF, 0, 8'h02, "R9");
        // R10: illegal combinations
        step(1, 1, 2, 2, 16'h0010, 0, 0, "R10");
        step(1, 2, 3, 2, 16'h0010, 7, 8'h03, "R10");
        step(1, 3, 1, 0, 16'h0010, 0, 0, "R10");
        step(1, 0, 1, 3, 16'h0010, 0, 0, "R10");
        // R2: back-to-back then idle
        step(0, 0, 1, 0, 16'h0000, 0, 0, "R2");
        step(0, 0, 1, 0, 16'h0000, 0, 0, "R2");
        // R11 and mixed traffic
        for (int i = 0; i < 400; i++) begin
            int sp = int'($urandom_range(3, 0));
            int md = int'($urandom_range(3, 0));
            int pr = int'($urandom_range(3, 0));
            bit v  = ($urandom_range(3, 0) != 0);
            step(v, sp, md, pr, int'($urandom_range(65535, 0)), int'($urandom_range(63, 0)),
                 int'($urandom_range(255, 0)), v ? pick_tag(sp, md, pr) : "R2");
        end
        step(0, 0, 0, 0, 0, 0, 0, "R11");
        @(negedge clk);
        compare_front();
        finished = 1'b1;
        finish_run();
    end
endmodule